// File: doc/BRIEF.md
# Shared Interrupt Affinity Router

This block keeps one 64-bit routing slot for every shared peripheral interrupt. Software writes a packed affinity value into the slot, and the block compares that value at once against a small table that gives each core's own affinity. The block records the index of the matching core and keeps a bitmap for each core of the interrupts routed to it. Downstream delivery logic reads those bitmaps and never has to compare an affinity itself.

The written value is stored exactly as given, so it reads back unchanged even when it names no existing core. Such an interrupt gets the reserved not-allocated index and is left out of every bitmap. A write updates everything on the same clock edge: the interrupt leaves the old core's bitmap, joins the new core's bitmap, and the new index is stored. The slots sit on a simple 32-bit register bus. Only the low word of each slot holds state.

Top module: `irq_route_ctrl`

## Requirements
- R1: The slot for shared interrupt n starts at byte address PRIV_SLOTS*8 + 8*n (0x100 + 8*n with the defaults). Writing a slot changes only that interrupt's recorded core index.
- R2: The upper word of each slot (address bit 2 set within the slot) reads as zero, and writes to it change nothing.
- R3: A read of the low word returns the last 32-bit value written to it, all four affinity bytes (level 0 in [7:0] up to level 3 in [31:24]) exactly as written.
- R4: A write whose value equals some core's affinity records that core's index in `irq_core` and sets the interrupt's bit in that core's bitmap. Both take effect on the write's clock edge.
- R5: On that same edge, the interrupt's bit is cleared in the bitmap of the core it was previously routed to.
- R6: A write whose value matches no core records index 0xFF and leaves the interrupt's bit clear in every bitmap. The value still reads back as written.
- R7: After reset every interrupt is routed to core 0: index 0, core 0's bitmap all ones, the other bitmaps zero. A read of any slot returns core 0's affinity.
- R8: Rewriting an interrupt to the core it already targets leaves that core's bit set.
- R9: Accesses below the first slot or past the last slot read as zero and are ignored on write.
- R10: Read data and `bus_rvalid` appear on the clock edge after the read request. `bus_rvalid` is high for exactly one cycle per read.
- R11: When several cores share the written affinity, the lowest-numbered of them is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| core_aff | input | NUM_CORE*32 | Packed affinity of each core, core c in bits [32c+31:32c] |
| core_targets | output | NUM_CORE*NUM_IRQ | Per-core bitmap, core c's bit n at index c*NUM_IRQ+n |
| irq_core | output | NUM_IRQ*8 | Recorded core index per interrupt, 0xFF = not allocated |

## Verification
A single write both removes an interrupt from one core's bitmap and adds it to another's, and both changes land on the same edge. The bench moves interrupts between different cores, and out of and back into the not-allocated state. It samples both bitmaps in the half cycle after the write and checks them. A same-core rewrite, where the clear and the set aim at the same bit, is run separately and must leave the bit set.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned AFF_W      = 32;
  localparam int unsigned CORE_IDX_W = 8;
  localparam logic [CORE_IDX_W-1:0] CORE_NONE = 8'hFF;

  typedef logic [AFF_W-1:0]      aff_t;
  typedef logic [CORE_IDX_W-1:0] core_idx_t;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_IRQ    = 32,
  parameter int unsigned PRIV_SLOTS = 32,
  parameter int unsigned IDX_W      = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic              lo_word,
  output logic [IDX_W-1:0]  slot
);
  localparam int unsigned BASE  = PRIV_SLOTS * 8;
  localparam int unsigned LIMIT = BASE + NUM_IRQ * 8;

  logic [ADDR_W-1:0] off;
  logic              unused_bits;

  always_comb begin
    off      = addr - ADDR_W'(BASE);
    in_range = (addr >= ADDR_W'(BASE)) && (addr < ADDR_W'(LIMIT));
    lo_word  = ~off[2];
    slot     = off[IDX_W+2:3];
  end

  assign unused_bits = ^{off[1:0], off[ADDR_W-1:IDX_W+3]};
endmodule

// File: rtl/irq_aff_match.sv
module irq_aff_match
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_CORE = 4
) (
  input  aff_t                    key,
  input  logic [NUM_CORE*AFF_W-1:0] aff_tab,
  output logic                    hit,
  output core_idx_t               idx
);
  logic [NUM_CORE-1:0] eq;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_cmp
    assign eq[c] = (aff_tab[c*AFF_W +: AFF_W] == key);
  end

  // Lowest matching core wins: scan downward so the last hit kept is lowest.
  always_comb begin
    hit = 1'b0;
    idx = CORE_NONE;
    for (int c = NUM_CORE - 1; c >= 0; c--) begin
      if (eq[c]) begin
        hit = 1'b1;
        idx = core_idx_t'(c);
      end
    end
  end

  // AST_HIT_IDX_VALID -- R11
  always_comb begin
    if (hit) assert (idx < core_idx_t'(NUM_CORE) && eq[idx[$clog2(NUM_CORE+1)-1:0]]);
  end
endmodule

// File: rtl/irq_route_store.sv
module irq_route_store
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IRQ-1:0]           wr_sel,
  input  aff_t                         wr_data,
  input  logic                         new_hit,
  input  core_idx_t                    new_idx,
  input  aff_t                         core0_aff,
  input  logic [IDX_W-1:0]             rd_slot,
  output aff_t                         rd_val,
  output logic [NUM_IRQ*CORE_IDX_W-1:0] idx_flat
);
  aff_t                 aff_q   [NUM_IRQ];
  aff_t                 aff_d   [NUM_IRQ];
  core_idx_t            idx_q   [NUM_IRQ];
  core_idx_t            idx_d   [NUM_IRQ];
  logic [NUM_IRQ-1:0]   dflt_q;
  logic [NUM_IRQ-1:0]   dflt_d;

  // next state
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      aff_d[i]  = aff_q[i];
      idx_d[i]  = idx_q[i];
      dflt_d[i] = dflt_q[i];
      if (wr_sel[i]) begin
        aff_d[i]  = wr_data;
        idx_d[i]  = new_hit ? new_idx : CORE_NONE;
        dflt_d[i] = 1'b0;
      end
    end
  end

  // registers; slots not yet written follow core 0's affinity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        aff_q[i] <= '0;
        idx_q[i] <= '0;
      end
      dflt_q <= '1;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (wr_sel[i]) begin
          aff_q[i] <= aff_d[i];
          idx_q[i] <= idx_d[i];
        end
      end
      dflt_q <= dflt_d;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (rd_slot == IDX_W'(i)) rd_val = dflt_q[i] ? core0_aff : aff_q[i];
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_out
    assign idx_flat[i*CORE_IDX_W +: CORE_IDX_W] = idx_q[i];

    // AST_WRITE_KEEPS_VALUE -- R3
    a_keep : assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] |=> (aff_q[i] == $past(wr_data) && !dflt_q[i]))
      else $error("AST_WRITE_KEEPS_VALUE");
  end
endmodule

// File: rtl/irq_target_map.sv
module irq_target_map
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 32,
  parameter int unsigned NUM_CORE = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IRQ-1:0]            wr_sel,
  input  logic [NUM_IRQ*CORE_IDX_W-1:0] old_idx_flat,
  input  logic                          new_hit,
  input  core_idx_t                     new_idx,
  output logic [NUM_CORE*NUM_IRQ-1:0]   tgt_flat
);
  logic [NUM_IRQ-1:0] tgt_q [NUM_CORE];
  logic [NUM_IRQ-1:0] tgt_d [NUM_CORE];

  // next state: clear at the old core, then set at the new one (set wins)
  always_comb begin
    for (int c = 0; c < NUM_CORE; c++) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        tgt_d[c][i] = tgt_q[c][i];
        if (wr_sel[i] && old_idx_flat[i*CORE_IDX_W +: CORE_IDX_W] == core_idx_t'(c))
          tgt_d[c][i] = 1'b0;
        if (wr_sel[i] && new_hit && new_idx == core_idx_t'(c))
          tgt_d[c][i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CORE; c++) tgt_q[c] <= (c == 0) ? '1 : '0;
    end else begin
      for (int c = 0; c < NUM_CORE; c++) begin
        if (|wr_sel) tgt_q[c] <= tgt_d[c];
      end
    end
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_flat
    assign tgt_flat[c*NUM_IRQ +: NUM_IRQ] = tgt_q[c];
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_col
    logic [NUM_CORE-1:0] col;
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_bit
      assign col[c] = tgt_q[c][i];
    end
    // AST_ONE_TARGET -- R4
    a_one : assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col))
      else $error("AST_ONE_TARGET");
    // AST_HIT_SETS_BIT -- R4
    a_set : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[i] && new_hit) |=> $countones(col) == 1)
      else $error("AST_HIT_SETS_BIT");
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_IRQ    = 32,
  parameter int unsigned NUM_CORE   = 4,
  parameter int unsigned PRIV_SLOTS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_req,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic                          bus_rvalid,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_CORE*32-1:0]        core_aff,
  output logic [NUM_CORE*NUM_IRQ-1:0]   core_targets,
  output logic [NUM_IRQ*8-1:0]          irq_core
);
  // core indices are 8 bits with 0xFF reserved: NUM_CORE must stay below 256
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic             in_range;
  logic             lo_word;
  logic [IDX_W-1:0] slot;
  logic             wr_ok;
  logic             rd_req;
  logic [NUM_IRQ-1:0] wr_sel;
  logic             new_hit;
  core_idx_t        new_idx;
  aff_t             rd_val;
  logic [31:0]      rdata_d;
  logic [31:0]      rdata_q;
  logic             rvalid_q;

  irq_route_decode #(
    .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .PRIV_SLOTS(PRIV_SLOTS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .in_range(in_range), .lo_word(lo_word), .slot(slot)
  );

  irq_aff_match #(.NUM_CORE(NUM_CORE)) u_match (
    .key(bus_wdata), .aff_tab(core_aff), .hit(new_hit), .idx(new_idx)
  );

  assign wr_ok  = bus_req && bus_we && in_range && lo_word;
  assign rd_req = bus_req && !bus_we;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_sel
    assign wr_sel[i] = wr_ok && (slot == IDX_W'(i));
  end

  irq_route_store #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(bus_wdata),
    .new_hit(new_hit), .new_idx(new_idx), .core0_aff(core_aff[AFF_W-1:0]),
    .rd_slot(slot), .rd_val(rd_val), .idx_flat(irq_core)
  );

  irq_target_map #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .old_idx_flat(irq_core),
    .new_hit(new_hit), .new_idx(new_idx), .tgt_flat(core_targets)
  );

  // read path next state
  always_comb begin
    rdata_d = (in_range && lo_word) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (rd_req) rdata_q <= rdata_d;
      rvalid_q <= rd_req;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // AST_RVALID_PULSE -- R10
  a_rvalid : assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid) else $error("AST_RVALID_PULSE");
  // AST_UPPER_RAZ -- R2
  a_upper : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !lo_word) |=> bus_rdata == '0) else $error("AST_UPPER_RAZ");
  // AST_IGNORED_STABLE -- R9
  a_ign : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !(in_range && lo_word)) |=> $stable(irq_core) && $stable(core_targets))
    else $error("AST_IGNORED_STABLE");

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    // AST_UNALLOC_EMPTY -- R6
    a_none : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_core[i*8 +: 8] == CORE_NONE) |-> !(|{core_targets[i]}) )
      else $error("AST_UNALLOC_EMPTY");
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      // AST_MAP_AGREES -- R5
      a_agree : assert property (@(posedge clk) disable iff (!rst_n)
        core_targets[c*NUM_IRQ + i] == (irq_core[i*8 +: 8] == core_idx_t'(c)))
        else $error("AST_MAP_AGREES");
    end
  end
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  localparam int NI = 32;
  localparam int NC = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_req = 1'b0;
  logic             bus_we = 1'b0;
  logic [15:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic             bus_rvalid;
  logic [31:0]      bus_rdata;
  logic [NC*32-1:0] core_aff;
  logic [NC*NI-1:0] core_targets;
  logic [NI*8-1:0]  irq_core;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // core3 shares core1's affinity (R11)
  assign core_aff = {32'h0000_0101, 32'h0001_0000, 32'h0000_0101, 32'h0000_0100};

  irq_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .core_aff(core_aff), .core_targets(core_targets),
    .irq_core(irq_core)
  );

  always #10 clk = ~clk;

  // {is_write, addr, wdata, expected read}
  localparam logic [80:0] VEC [0:11] = '{
    {1'b0, 16'h0100, 32'h0,         32'h0000_0100},  // R7 reset readback
    {1'b1, 16'h0108, 32'h0001_0000, 32'h0},          // irq1 -> core2
    {1'b0, 16'h0108, 32'h0,         32'h0001_0000},  // R3
    {1'b0, 16'h010C, 32'h0,         32'h0},          // R2
    {1'b1, 16'h010C, 32'hFFFF_FFFF, 32'h0},          // R2 ignored
    {1'b0, 16'h010C, 32'h0,         32'h0},          // R2
    {1'b0, 16'h0108, 32'h0,         32'h0001_0000},  // R2 low word intact
    {1'b1, 16'h01F8, 32'hAB00_0101, 32'h0},          // irq31 no match
    {1'b0, 16'h01F8, 32'h0,         32'hAB00_0101},  // R6 readback
    {1'b1, 16'h00F8, 32'h0000_0101, 32'h0},          // R9 below
    {1'b0, 16'h00F8, 32'h0,         32'h0},          // R9
    {1'b0, 16'h0200, 32'h0,         32'h0}           // R9 past end
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
    chk("R10 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  function automatic logic [31:0] map_of(int c);
    return core_targets[c*NI +: NI];
  endfunction

  function automatic logic [31:0] core_of(int i);
    return 32'(irq_core[i*8 +: 8]);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7 core0 map", map_of(0), 32'hFFFF_FFFF);
    for (int c = 1; c < NC; c++) chk("R7 other map", map_of(c), 32'h0);
    for (int i = 0; i < NI; i++) chk("R7 index", core_of(i), 32'h0);
    chk("R10 idle rvalid", 32'(bus_rvalid), 32'd0);

    for (int k = 0; k < 12; k++) begin
      if (VEC[k][80]) wr(VEC[k][79:64], VEC[k][63:32]);
      else begin
        rd(VEC[k][79:64], d);
        chk($sformatf("R3/R2/R9 vector %0d", k), d, VEC[k][31:0]);
      end
    end
    @(negedge clk);
    chk("R10 one-cycle rvalid", 32'(bus_rvalid), 32'd0);
    chk("R4 irq1 index", core_of(1), 32'd2);
    chk("R4 core2 map", map_of(2), 32'h0000_0002);
    chk("R6 irq31 index", core_of(31), 32'hFF);
    chk("R5 R6 core0 map", map_of(0), 32'h7FFF_FFFD);
    chk("R6 core1 map", map_of(1), 32'h0);
    chk("R6 core3 map", map_of(3), 32'h0);

    // R11: shared affinity goes to lowest core
    wr(16'h0110, 32'h0000_0101);
    chk("R11 irq2 index", core_of(2), 32'd1);
    chk("R11 core1 map", map_of(1), 32'h0000_0004);
    chk("R11 core3 map", map_of(3), 32'h0);
    chk("R5 core0 map", map_of(0), 32'h7FFF_FFF9);
    // R8: same-core rewrite
    wr(16'h0110, 32'h0000_0101);
    chk("R8 core1 map", map_of(1), 32'h0000_0004);
    // R5: move irq1 from core2 to core0, sampled right after the edge
    wr(16'h0108, 32'h0000_0100);
    chk("R5 core2 cleared", map_of(2), 32'h0);
    chk("R4 core0 set", map_of(0), 32'h7FFF_FFFB);
    // R1: slot address to index
    wr(16'h0128, 32'h0001_0000);
    chk("R1 irq5 index", core_of(5), 32'd2);
    chk("R1 irq4 index", core_of(4), 32'd0);
    chk("R1 irq6 index", core_of(6), 32'd0);
    chk("R1 core2 map", map_of(2), 32'h0000_0020);
    // R4: unallocated back to a core
    wr(16'h01F8, 32'h0000_0100);
    chk("R4 irq31 index", core_of(31), 32'd0);
    chk("R4 core0 map", map_of(0), 32'hFFFF_FFDB);
    rd(16'h01F8, d);
    chk("R3 irq31 readback", d, 32'h0000_0100);
    rd(16'h01FC, d);
    chk("R2 irq31 upper", d, 32'h0);
    rd(16'h0118, d);
    chk("R7 unwritten slot", d, 32'h0000_0100);

    finish_run();
  end
endmodule